// File: doc/BRIEF.md
# LIN Slave Header Detector

This block is the receive front end of a LIN slave node. It watches the synchronized receive line and recognises a break as a long dominant (low) stretch. It then times the 0x55 synch character that follows and, when automatic synchronization is on, derives the baud divider from that measurement. A header flag marks a complete header and can drive an interrupt. A synch-state flag shows when the synch character is being analysed.

A mode input selects when a header counts as complete. In the first mode the break alone is enough. In the second mode a break, a valid synch character and an identifier character must arrive in sequence. The baud divider has a mantissa register and a fraction register. Software may load either register as a whole. A measured synch character reloads both registers. Software clears the header flag in two steps: a status access made while the flag is set, followed by a control read.

Top module: `lin_hdr_det`

## Requirements
- R1: After reset the header flag, synch-state flag and interrupt are 0, and both divider registers read 0.
- R2: While the mantissa is 0 the serial clock is off and no break is recognised, however long the line stays low.
- R3: A break is recognised once the line has been low for 11 × (16 × mantissa + fraction) clock cycles. One cycle fewer is not a break. Recognition sets the synch-state flag.
- R4: With mode = 0, the header flag is set when the break is recognised.
- R5: With mode = 1, the header flag stays 0 after the break and after the synch character. It is set 10 bit times after the falling edge that starts the identifier character, where one bit time is 16 × mantissa + fraction cycles.
- R6: The span S is measured in cycles from the 1st to the 5th falling edge of the synch character. With auto-sync = 1, a valid measurement loads Q = floor((S + 4) / 8), with mantissa = Q[11:4] and fraction = Q[3:0]. With auto-sync = 0 the divider is left unchanged.
- R7: The synch-state flag clears when the 5th falling edge of the synch character has been measured.
- R8: The header flag clears only when a status access made while the flag is 1 is followed by a control-3 read. A control-3 read on its own leaves the flag set.
- R9: The interrupt output equals the header flag ANDed with the interrupt enable sampled one cycle earlier.
- R10: A software synch-state clear drops the synch-state flag and returns the block to break search. A synch character that follows is not measured.
- R11: If a header attempt does not complete within TOUT_CYC cycles after its break, it is dropped and the synch-state flag clears.
- R12: A new break that arrives during analysis drops the attempt, clears the synch-state flag and sets no header.
- R13: A measurement with Q < 16 or Q ≥ 4096 drops the attempt and leaves the divider unchanged.
- R14: A write pulse loads the whole mantissa (wr_data[7:0]) or the whole fraction (wr_data[3:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial receive line, idle high |
| hdr_mode | input | 1 | 0: break completes a header; 1: break, synch and identifier |
| auto_sync | input | 1 | Load the divider from the synch measurement |
| hdr_irq_en | input | 1 | Header interrupt enable |
| status_access | input | 1 | Pulse: status register accessed (first clear step) |
| ctl3_read | input | 1 | Pulse: control register 3 read (second clear step) |
| sfs_clear | input | 1 | Pulse: software clear of the synch-state flag |
| wr_mant | input | 1 | Pulse: write the mantissa from wr_data |
| wr_frac | input | 1 | Pulse: write the fraction from wr_data |
| wr_data | input | 8 | Write data for the divider registers |
| div_mant | output | 8 | Divider mantissa |
| div_frac | output | 4 | Divider fraction |
| hdr_flag | output | 1 | Header detected flag |
| sfs_flag | output | 1 | Synch character under analysis |
| hdr_irq | output | 1 | Header interrupt |

## Verification
The line passes through two synchronizer stages and an edge register. Break and edge results therefore reach the flags within four clock cycles of the pin event, and divider loads land two cycles after the 5th synch edge. The header flag in mode 1 rises a few cycles after the stop bit of the identifier ends. Clear and write pulses take effect on the next edge. The bench therefore reads each flag and the divider only after the line has been idle for at least twenty cycles following the stimulus. Each break boundary is judged only after the line has returned high, when the outcome is settled.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELIM,
    ST_SYNC,
    ST_IDWAIT,
    ST_IDRX
  } hdr_state_t;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  output logic rx_lvl,
  output logic rx_fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], rx_pin};
      prev <= sh[STAGES-1];
    end
  end

  assign rx_lvl  = sh[STAGES-1];
  assign rx_fall = prev & ~sh[STAGES-1];
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int DW       = 12,
  parameter int BRK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_lvl,
  input  logic          en,
  input  logic [DW-1:0] bit_len,
  output logic          brk
);
  localparam int MW = DW + $clog2(BRK_BITS + 1);

  logic [MW-1:0] low_cnt;
  logic [MW-1:0] thr;

  assign thr = MW'(bit_len) * MW'(BRK_BITS);

  always_ff @(posedge clk) begin
    if (rst || rx_lvl) low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  // pulse on the low cycle whose count equals the threshold
  assign brk = en && !rx_lvl && (thr != '0) && (low_cnt == thr - 1'b1);
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas #(
  parameter int TW    = 16,
  parameter int EDGES = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        fall,
  output logic        done,
  output logic [TW:0] span
);
  localparam int EW = $clog2(EDGES + 1);

  logic [EW-1:0] edges;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      edges <= '0;
      tmr   <= '0;
      done  <= 1'b0;
      span  <= '0;
    end else begin
      done <= 1'b0;
      if (edges != '0 && tmr != '1) tmr <= tmr + 1'b1;
      if (fall) begin
        if (edges == '0) begin
          edges <= EW'(1);
          tmr   <= '0;
        end else if (edges == EW'(EDGES - 1)) begin
          edges <= '0;
          done  <= 1'b1;
          span  <= {1'b0, tmr} + (TW+1)'(1);
        end else begin
          edges <= edges + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lin_hdr_flag.sv
module lin_hdr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic st_acc,
  input  logic c3_rd,
  input  logic ie,
  output logic hdr,
  output logic irq
);
  logic armed;
  logic hdr_n;

  always_comb begin
    hdr_n = hdr;
    if (set) hdr_n = 1'b1;
    else if (armed && c3_rd) hdr_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr   <= 1'b0;
      irq   <= 1'b0;
      armed <= 1'b0;
    end else begin
      hdr <= hdr_n;
      irq <= ie & hdr_n;
      if (c3_rd) armed <= 1'b0;
      else if (st_acc && hdr) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/lin_hdr_det.sv
module lin_hdr_det
  import lin_hdr_pkg::*;
#(
  parameter int MANT_W      = 8,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TOUT_CYC    = 40000,
  parameter int BRK_BITS    = 11,
  parameter int ID_BITS     = 10,
  parameter int SPAN_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_pin,
  input  logic              hdr_mode,
  input  logic              auto_sync,
  input  logic              hdr_irq_en,
  input  logic              status_access,
  input  logic              ctl3_read,
  input  logic              sfs_clear,
  input  logic              wr_mant,
  input  logic              wr_frac,
  input  logic [MANT_W-1:0] wr_data,
  output logic [MANT_W-1:0] div_mant,
  output logic [FRAC_W-1:0] div_frac,
  output logic              hdr_flag,
  output logic              sfs_flag,
  output logic              hdr_irq
);
  localparam int DW  = MANT_W + FRAC_W;
  localparam int TW  = $clog2(TOUT_CYC + 1);
  localparam int QW  = TW + 1;
  localparam int IDW = DW + $clog2(ID_BITS + 1);
  localparam int SH  = $clog2(SPAN_BITS);

  hdr_state_t     st, st_n;
  logic           rx_lvl, rx_fall, brk, meas_done;
  logic [TW:0]    span;
  logic [QW-1:0]  q;
  logic           div_ok, hdr_set, load_div;
  logic [TW-1:0]  tcnt;
  logic [IDW-1:0] idcnt, id_len;
  logic [DW-1:0]  bit_len;
  logic           in_sfs;

  assign bit_len = {div_mant, div_frac};
  assign id_len  = IDW'(bit_len) * IDW'(ID_BITS);

  lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .rx_lvl(rx_lvl), .rx_fall(rx_fall)
  );

  lin_brk_det #(.DW(DW), .BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst(rst), .rx_lvl(rx_lvl), .en(div_mant != '0),
    .bit_len(bit_len), .brk(brk)
  );

  lin_sync_meas #(.TW(TW), .EDGES(5)) u_meas (
    .clk(clk), .rst(rst), .clr(st != ST_SYNC), .fall(rx_fall),
    .done(meas_done), .span(span)
  );

  lin_hdr_flag u_flag (
    .clk(clk), .rst(rst), .set(hdr_set), .st_acc(status_access),
    .c3_rd(ctl3_read), .ie(hdr_irq_en), .hdr(hdr_flag), .irq(hdr_irq)
  );

  // rounded span/8 in sixteenths of a bit
  assign q      = (span + QW'(SPAN_BITS / 2)) >> SH;
  assign div_ok = (q >= QW'(1 << FRAC_W)) && ((q >> DW) == '0);
  assign in_sfs = (st == ST_DELIM) || (st == ST_SYNC);

  always_comb begin
    st_n     = st;
    hdr_set  = 1'b0;
    load_div = 1'b0;
    case (st)
      ST_IDLE: begin
        if (brk) begin
          st_n    = ST_DELIM;
          hdr_set = !hdr_mode;
        end
      end
      ST_DELIM: if (rx_lvl) st_n = ST_SYNC;
      ST_SYNC: begin
        if (meas_done) begin
          if (!div_ok) st_n = ST_IDLE;
          else begin
            load_div = auto_sync;
            st_n     = hdr_mode ? ST_IDWAIT : ST_IDLE;
          end
        end
      end
      ST_IDWAIT: if (rx_fall) st_n = ST_IDRX;
      ST_IDRX: begin
        if (idcnt == id_len - 1'b1) begin
          hdr_set = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (st != ST_IDLE) begin
      if (brk || (tcnt == TW'(TOUT_CYC - 1)) || (sfs_clear && in_sfs)) begin
        st_n     = ST_IDLE;
        hdr_set  = 1'b0;
        load_div = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tcnt     <= '0;
      idcnt    <= '0;
      sfs_flag <= 1'b0;
      div_mant <= '0;
      div_frac <= '0;
    end else begin
      st       <= st_n;
      tcnt     <= (st == ST_IDLE) ? '0 : tcnt + 1'b1;
      idcnt    <= (st == ST_IDRX) ? idcnt + 1'b1 : '0;
      sfs_flag <= (st_n == ST_DELIM) || (st_n == ST_SYNC);
      if (load_div) begin
        {div_mant, div_frac} <= q[DW-1:0];
      end else begin
        if (wr_mant) div_mant <= wr_data;
        if (wr_frac) div_frac <= wr_data[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lin_hdr_det_chk.sv
module lin_hdr_det_chk #(
  parameter int MANT_W = 8,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_mode,
  input logic              hdr_irq_en,
  input logic              ctl3_read,
  input logic              wr_mant,
  input logic              wr_frac,
  input logic [MANT_W-1:0] div_mant,
  input logic [FRAC_W-1:0] div_frac,
  input logic              hdr_flag,
  input logic              sfs_flag,
  input logic              hdr_irq
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!hdr_flag && !sfs_flag && !hdr_irq && div_mant == '0 && div_frac == '0));

  a_r2_off_no_break: assert property (@(posedge clk) disable iff (rst)
    (div_mant == '0 && !sfs_flag) |=> !sfs_flag);

  a_r4_mode0_hdr_at_break: assert property (@(posedge clk) disable iff (rst)
    ($rose(sfs_flag) && !$past(hdr_mode)) |-> hdr_flag);

  a_r5_mode1_hdr_after_sync: assert property (@(posedge clk) disable iff (rst)
    ($rose(hdr_flag) && $past(hdr_mode)) |-> !$past(sfs_flag));

  a_r6_div_changes_by_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable({div_mant, div_frac}) |-> ($past(wr_mant) || $past(wr_frac) || $past(sfs_flag)));

  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
    $fell(hdr_flag) |-> $past(ctl3_read));

  a_r9_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hdr_irq == ($past(hdr_irq_en) && hdr_flag)));
endmodule

bind lin_hdr_det lin_hdr_det_chk #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_mode(hdr_mode), .hdr_irq_en(hdr_irq_en),
  .ctl3_read(ctl3_read), .wr_mant(wr_mant), .wr_frac(wr_frac),
  .div_mant(div_mant), .div_frac(div_frac), .hdr_flag(hdr_flag),
  .sfs_flag(sfs_flag), .hdr_irq(hdr_irq)
);

// File: tb/sim_lin_hdr_det.sv
module sim_lin_hdr_det;
  localparam int TOUT = 4000;

  logic clk = 1'b0, rst = 1'b1, rx = 1'b1;
  logic mode = 1'b0, autos = 1'b0, ie = 1'b0;
  logic sacc = 1'b0, c3 = 1'b0, sclr = 1'b0, wm = 1'b0, wf = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] dm;
  logic [3:0] df;
  logic hf, sf, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  int cur_b = 0;

  always #5 clk = ~clk;

  lin_hdr_det #(.TOUT_CYC(TOUT)) u0 (
    .clk(clk), .rst(rst), .rx_pin(rx), .hdr_mode(mode), .auto_sync(autos),
    .hdr_irq_en(ie), .status_access(sacc), .ctl3_read(c3), .sfs_clear(sclr),
    .wr_mant(wm), .wr_frac(wf), .wr_data(wd), .div_mant(dm), .div_frac(df),
    .hdr_flag(hf), .sfs_flag(sf), .hdr_irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(int span);
    return (span + 4) >> 3;
  endfunction

  task automatic hold(logic v, int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(int b);
    wd = 8'(b >> 4); wm = 1'b1; @(negedge clk); wm = 1'b0;
    wd = 8'(b & 15); wf = 1'b1; @(negedge clk); wf = 1'b0;
    cur_b = b;
  endtask

  task automatic send_byte(int b, logic [7:0] d);
    hold(1'b0, b);
    for (int i = 0; i < 8; i++) hold(d[i], b);
    hold(1'b1, b);
  endtask

  // 0x55 with bit 6 stretched by extra cycles; span = 8*b + extra
  task automatic send_sync(int b, int extra);
    hold(1'b0, b);
    for (int i = 0; i < 8; i++) hold(((i % 2) == 0), (i == 6) ? b + extra : b);
    hold(1'b1, b);
  endtask

  task automatic clear_hdr();
    sacc = 1'b1; @(negedge clk); sacc = 1'b0;
    c3 = 1'b1; @(negedge clk); c3 = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int b, len;
    bit m, a;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hdr after reset", hf, 0);
    chk("R1 sfs after reset", sf, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 divider after reset", int'({dm, df}), 0);

    hold(1'b0, 3000); hold(1'b1, 20);
    chk("R2 no break while mantissa zero", sf, 0);
    chk("R2 no header while mantissa zero", hf, 0);

    set_div(37);
    chk("R14 mantissa write", dm, 2);
    chk("R14 fraction write", df, 5);
    set_div(32);
    autos = 1'b1; ie = 1'b1; mode = 1'b0;

    hold(1'b0, 351); hold(1'b1, 40);
    chk("R3 one cycle short is no break", sf, 0);
    hold(1'b0, 352); hold(1'b1, 10);
    chk("R3 break sets sfs", sf, 1);
    chk("R4 mode0 header at break", hf, 1);
    chk("R9 irq with enable", irq, 1);
    sclr = 1'b1; @(negedge clk); sclr = 1'b0;
    hold(1'b1, 10);
    chk("R10 software clear drops sfs", sf, 0);
    send_sync(40, 0); hold(1'b1, 20);
    chk("R10 sync after clear not measured", int'({dm, df}), 32);
    c3 = 1'b1; @(negedge clk); c3 = 1'b0; @(negedge clk);
    chk("R8 read alone keeps flag", hf, 1);
    clear_hdr();
    chk("R8 two-step clear", hf, 0);
    chk("R9 irq follows cleared flag", irq, 0);

    mode = 1'b1;
    hold(1'b0, 352); hold(1'b1, 32);
    chk("R11 sfs set before timeout", sf, 1);
    hold(1'b1, TOUT + 50);
    chk("R11 timeout clears sfs", sf, 0);
    chk("R11 timeout no header", hf, 0);

    hold(1'b0, 352); hold(1'b1, 32);
    hold(1'b0, 400); hold(1'b1, 40);
    chk("R12 break in analysis clears sfs", sf, 0);
    chk("R12 break in analysis no header", hf, 0);

    hold(1'b0, 352); hold(1'b1, 32);
    send_sync(8, 0); hold(1'b1, 40);
    chk("R13 too fast sync dropped", sf, 0);
    chk("R13 divider unchanged", int'({dm, df}), 32);
    chk("R13 no header", hf, 0);

    hold(1'b0, 352); hold(1'b1, 40);
    chk("R5 mode1 no header at break", hf, 0);
    send_sync(40, 4); hold(1'b1, 20);
    chk("R7 sfs cleared after sync", sf, 0);
    chk("R6 rounded up divider", int'({dm, df}), exp_div(324));
    chk("R5 mode1 no header after sync", hf, 0);
    send_byte(41, 8'hA3); hold(1'b1, 20);
    chk("R5 mode1 header after identifier", hf, 1);
    chk("R9 irq mode1", irq, 1);
    clear_hdr();
    cur_b = 41;

    mode = 1'b0;
    hold(1'b0, 460); hold(1'b1, 40);
    send_sync(40, 3); hold(1'b1, 20);
    chk("R6 rounded down divider", int'({dm, df}), exp_div(323));
    clear_hdr();
    autos = 1'b0;
    hold(1'b0, 450); hold(1'b1, 40);
    send_sync(50, 0); hold(1'b1, 20);
    chk("R6 auto off keeps divider", int'({dm, df}), 40);
    chk("R7 sfs cleared auto off", sf, 0);
    clear_hdr();
    cur_b = 40;

    for (int it = 0; it < 10; it++) begin
      b = 20 + int'($urandom % 71);
      m = 1'($urandom % 2);
      a = 1'($urandom % 2);
      ie = 1'($urandom % 2);
      mode = m; autos = a;
      if (!a) set_div(b);
      len = 11 * cur_b + int'($urandom % 32'(b + 1));
      hold(1'b0, len); hold(1'b1, b);
      chk("R3 random break sfs", sf, 1);
      chk(m ? "R5 random no early header" : "R4 random header at break", hf, m ? 0 : 1);
      send_sync(b, 0); hold(1'b1, b);
      chk("R7 random sfs cleared", sf, 0);
      chk("R6 random divider", int'({dm, df}), b);
      cur_b = b;
      if (m) begin
        send_byte(b, 8'($urandom)); hold(1'b1, 20);
      end
      chk("R5 random header set", hf, 1);
      chk("R9 random irq", irq, int'(ie));
      clear_hdr();
      chk("R8 random clear", hf, 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule